// File: doc/BRIEF.md
# Multi-mode baud tick generator

This block is the rate source for a serial port that can run in asynchronous or synchronous mode. It runs freely from the system clock and emits a one-cycle `tick` once per baud period. The period is the divisor value plus one, multiplied by a prescale factor of 64, 16 or 4. The factor depends on three mode inputs: the width select, the high-speed select and the synchronous select.

The divisor is held in two byte registers, loaded from an 8-bit bus through separate low and high write strobes. In 8-bit width only the low byte counts. In 16-bit width the high and low bytes together form the divisor.

Any divisor write, and any change of a mode input, clears the internal counters in the cycle of the event. The new rate therefore starts at once, and no stale partial period from the old setting carries over.

Top module: `baud_tick_gen`

## Requirements
- R1: During reset `tick` is 0. Both divisor bytes reset to 0, so with all mode inputs low the first tick comes exactly 64 clocks after reset is released.
- R2: Asynchronous mode (`sync_en`=0), `wide_en`=0, `fast_en`=0: the tick period is 64 x (n+1) clocks.
- R3: Asynchronous mode with exactly one of `wide_en` and `fast_en` set: the tick period is 16 x (n+1) clocks.
- R4: Asynchronous mode with `wide_en`=1 and `fast_en`=1: the tick period is 4 x (n+1) clocks.
- R5: With `sync_en`=1 the period is 4 x (n+1) clocks at either width, whatever `fast_en` is.
- R6: With `wide_en`=0, n is the low byte alone and the high byte has no effect. With `wide_en`=1, n is high byte x 256 + low byte. A strobe loads `wr_data` into its byte on the same clock edge.
- R7: A write strobe (`wr_lo` or `wr_hi`) sampled high on clock edge W clears the counters on that edge. The next tick is high right after edge W + P x (n+1), where P is the prescale factor and n is the new divisor.
- R8: A change of any mode input sampled on edge W restarts the count in the same way as R7, using the new mode.
- R9: `tick` is high for exactly one clock, and ticks repeat every period for as long as no restart occurs.
- R10: With n=25, all modes low and a 16 MHz clock, the period is 1664 clocks, which gives 9615 ticks per second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Byte written into the divisor register |
| wr_lo | input | 1 | Strobe that loads the low divisor byte |
| wr_hi | input | 1 | Strobe that loads the high divisor byte |
| wide_en | input | 1 | 1 selects the 16-bit divisor |
| fast_en | input | 1 | High-speed select, used only in asynchronous mode |
| sync_en | input | 1 | 1 selects synchronous mode |
| tick | output | 1 | One-cycle baud tick |

## Verification
Every combination of the three mode inputs is driven. Measuring both the latency from a write to the first tick and the gap between ticks separates the 64, 16 and 4 factors and shows that `fast_en` is ignored in synchronous mode. Setting a nonzero high byte while in 8-bit width tells the low-byte-only divisor from the 16-bit one. Writes and mode changes are also placed in the middle of a running period, which shows that the restart is immediate and is not deferred to the end of the period. Random mode and divisor draws with a fixed seed are compared against an expected period that the bench computes as a shift of 64.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIV_W   = 2 * BYTE_W;
  localparam int MAX_PRE = 64;
  localparam int PRE_W   = $clog2(MAX_PRE);

  typedef struct packed {
    logic wide;
    logic fast;
    logic sync;
  } mode_t;

  // prescale factor minus one for a mode
  function automatic logic [PRE_W-1:0] prescale_m1(input mode_t m);
    int f;
    if (m.sync)                f = 4;
    else if (m.wide && m.fast) f = 4;
    else if (m.wide ^ m.fast)  f = 16;
    else                       f = MAX_PRE;
    return PRE_W'(f - 1);
  endfunction

  // effective divisor from the two bytes and the width select
  function automatic logic [DIV_W-1:0] eff_divisor(input logic wide,
      input logic [BYTE_W-1:0] hi, input logic [BYTE_W-1:0] lo);
    return wide ? {hi, lo} : {{BYTE_W{1'b0}}, lo};
  endfunction
endpackage

// File: rtl/bg_divisor_regs.sv
module bg_divisor_regs
  import baud_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_lo,
  input  logic              wr_hi,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              wr_event
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= wr_data;
    end
  end

  assign wr_event = wr_lo | wr_hi;

  assert_lo_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wr_data)));
  assert_hi_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hi_q == $past(wr_data)));
endmodule

// File: rtl/bg_mode_watch.sv
module bg_mode_watch
  import baud_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode_in,
  output logic [PRE_W-1:0] pre_m1,
  output logic             mode_change
);
  mode_t mode_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_prev <= '0;
    else        mode_prev <= mode_in;
  end

  assign mode_change = (mode_in != mode_prev);
  assign pre_m1      = prescale_m1(mode_in);

  assert_mode_settles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> (mode_prev == $past(mode_in)));
endmodule

// File: rtl/bg_count_chain.sv
module bg_count_chain
  import baud_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_m1,
  input  logic [DIV_W-1:0] div_n,
  output logic             terminal
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_last;
  logic             div_last;

  assign pre_last = (pre_cnt == pre_m1);
  assign div_last = (div_cnt == div_n);
  assign terminal = pre_last && div_last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_last) begin
      pre_cnt <= '0;
      div_cnt <= div_last ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_cnt == '0 && div_cnt == '0));
  assert_pre_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (pre_cnt <= pre_m1));
  assert_div_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (div_cnt <= div_n));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  wr_data,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        wide_en,
  input  logic        fast_en,
  input  logic        sync_en,
  output logic        tick
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              wr_event, mode_change, restart, terminal;
  logic [PRE_W-1:0]  pre_m1;
  logic [DIV_W-1:0]  div_n;
  mode_t             mode_now;
  logic              tick_q;

  assign mode_now = '{wide: wide_en, fast: fast_en, sync: sync_en};

  bg_divisor_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .lo_q(lo_q), .hi_q(hi_q), .wr_event(wr_event)
  );

  bg_mode_watch u_mode (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_now),
    .pre_m1(pre_m1), .mode_change(mode_change)
  );

  assign div_n   = eff_divisor(wide_en, hi_q, lo_q);
  assign restart = wr_event | mode_change;

  bg_count_chain u_chain (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pre_m1(pre_m1),
    .div_n(div_n), .terminal(terminal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= terminal && !restart;
  end

  assign tick = tick_q;

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_no_tick_after_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_lo = 1'b0, wr_hi = 1'b0;
  logic wide_en = 1'b0, fast_en = 1'b0, sync_en = 1'b0;
  logic tick;
  int n_chk = 0, n_bad = 0;
  int seed = 12345;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wide_en(wide_en), .fast_en(fast_en), .sync_en(sync_en), .tick(tick)
  );

  function automatic int exp_period(input bit w, input bit f, input bit s,
                                    input int hi, input int lo);
    int shift, n;
    shift = s ? 2 : ((w ? 1 : 0) + (f ? 1 : 0));
    n = w ? (hi * 256 + lo) : lo;
    return (64 >> (2 * shift)) * (n + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input bit hi, input int val);
    @(negedge clk);
    wr_data = 8'(val);
    if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic set_modes(input bit w, input bit f, input bit s);
    @(negedge clk);
    wide_en = w; fast_en = f; sync_en = s;
    @(negedge clk);
  endtask

  task automatic cycles_to_tick(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!tick && cnt < 20000);
  endtask

  // configure, then check latency, single-cycle width and period
  task automatic run_case(input bit w, input bit f, input bit s, input int hi,
                          input int lo, input string req);
    int c, e;
    set_modes(w, f, s);
    write_byte(1'b1, hi);
    write_byte(1'b0, lo);
    e = exp_period(w, f, s, hi, lo);
    cycles_to_tick(c);
    chk(c == e, {req, " latency R7"}, c, e);
    cycles_to_tick(c);
    chk(c == e, {req, " period R9"}, c, e);
  endtask

  initial begin
    int c, e;
    void'($urandom(seed));
    repeat (4) begin
      @(negedge clk);
      chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    end
    rst_n = 1'b1;
    cycles_to_tick(c);
    chk(c == 64, "R1 first tick after reset", c, 64);

    // R10 / R2 worked example
    run_case(0, 0, 0, 0, 25, "R2 R10");
    @(negedge clk);
    chk(tick == 1'b0, "R9 tick one cycle", int'(tick), 0);
    chk(16000000 / 1664 == 9615 && exp_period(0, 0, 0, 0, 25) == 1664,
        "R10 rate", 16000000 / 1664, 9615);

    run_case(0, 1, 0, 5, 10, "R3 R6 narrow fast hi ignored");
    run_case(1, 0, 0, 1, 2, "R3 R6 wide slow");
    run_case(1, 1, 0, 0, 99, "R4 wide fast");
    run_case(0, 1, 1, 3, 7, "R5 sync fast");
    run_case(1, 0, 1, 0, 9, "R5 sync wide");

    // R8 mode change mid-period
    run_case(0, 0, 0, 0, 25, "R2 base");
    repeat (500) @(negedge clk);
    set_modes(0, 1, 0);
    cycles_to_tick(c);
    e = exp_period(0, 1, 0, 0, 25);
    chk(c == e, "R8 mode change restart", c, e);

    // R5 fast flipped in sync mode still 4x
    set_modes(0, 1, 1);
    cycles_to_tick(c);
    set_modes(0, 0, 1);
    cycles_to_tick(c);
    e = exp_period(0, 0, 1, 0, 25);
    chk(c == e, "R5 R8 sync fast ignored", c, e);

    // R7 write mid-period
    set_modes(0, 0, 0);
    repeat (300) @(negedge clk);
    write_byte(1'b0, 3);
    cycles_to_tick(c);
    chk(c == 256, "R7 mid-period write", c, 256);

    // R6 high byte write in narrow mode has no effect on period
    write_byte(1'b1, 200);
    cycles_to_tick(c);
    chk(c == 256, "R6 hi ignored narrow", c, 256);

    for (int i = 0; i < 8; i++) begin
      bit w, f, s;
      int hi, lo;
      w = 1'($urandom); f = 1'($urandom); s = 1'($urandom);
      hi = int'($urandom % 2); lo = int'($urandom % 48);
      run_case(w, f, s, hi, lo, "R2 R3 R4 R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule